// File: doc/BRIEF.md
# Mode-Configurable Crosstalk-Aware ECC Link Encoder

This block protects a 32-bit flit on its way across a wide on-chip link. It computes seven check bits with an odd-weight-column (Hsiao) SECDED code, which gives a 39-bit codeword. It registers that codeword and then spreads it over 78 wires. Each flit is sent in one of three configurations, chosen by a 2-bit mode input:

- **Duplicated SECDED:** every codeword bit drives two neighbouring wires.
- **Shielded SECDED:** codeword bits sit on the even wires and every odd wire is held at ground.
- **Shielded SEC:** the same shielded layout, with the top check bit removed as well.

The two SECDED configurations work with a receiver that can ask for a word again. For them the encoder keeps the last codeword it sent in a one-entry replay store. When a request arrives, the stored word goes back out on the link in place of new data. In the SEC configuration the store's write enable is held off, and requests are ignored.

The replay store is run by a three-state machine:

| State | Meaning |
|---|---|
| `BUF_EMPTY` | Nothing valid is stored. |
| `BUF_HELD` | A valid SECDED word is stored. |
| `BUF_OFF` | The store is gated. |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| `GATE` | any state | `BUF_OFF` | The mode is SEC. |
| `LOAD` | any state | `BUF_HELD` | The mode is SECDED and a flit is accepted. |
| `WAKE` | `BUF_OFF` | `BUF_EMPTY` | The mode is SECDED and no flit is accepted. |
| `KEEP` | `BUF_EMPTY` or `BUF_HELD` | unchanged | Otherwise. |

The store does not capture words while it is gated. A word left over from before the SEC period is therefore never replayed.

Top module: `xtalk_ecc_encoder`

## Requirements
- R1: After reset all 78 link wires are 0 and ready is 1. A replay request made before any SECDED flit has been sent is ignored: ready stays 1 and the link does not change.
- R2: The codeword places data bit i at codeword bit i (0..31) and check bit j at codeword bit 32+j. Data bit i has as its column the i-th smallest 7-bit value (counting from 0) with exactly three ones. Check bit j is the XOR of every data bit whose column has bit j set.
- R3: Mode bit 1 set selects duplication and clear selects shielding. Mode bit 0 set selects SECDED and clear selects SEC. Mode 2'b10 behaves exactly like 2'b11.
- R4: With duplication, codeword bit i drives both wire 2i and wire 2i+1.
- R5: With shielding, codeword bit i drives wire 2i and every odd wire is 0.
- R6: In SEC mode (2'b00), codeword bit 38 (the top check bit, wire 76) is 0. The other check bits match SECDED.
- R7: A flit is accepted when valid and ready are both 1 at a rising edge. Its mapped codeword is on the link from that edge on. With no accepted flit and no replay, the link keeps its value.
- R8: In a SECDED mode with a stored word, a replay request drops ready in the same cycle. At the next edge the stored word appears, mapped as it was when first sent, and the flit offered in that cycle is not accepted.
- R9: In SEC mode, ready stays 1 under a replay request and the store is not written. After a return to a SECDED mode, requests are ignored until a SECDED flit has been sent.
- R10: The store keeps the most recent SECDED codeword, so repeated replay requests keep that same word on the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flit_i | input | 32 | Flit data to encode |
| flit_valid_i | input | 1 | Flit offered this cycle |
| mode_i | input | 2 | Bit 1: duplicate (1) or shield (0); bit 0: SECDED (1) or SEC (0) |
| replay_req_i | input | 1 | Receiver asks for the last word again |
| link_o | output | 78 | Registered link wires |
| ready_o | output | 1 | Flit can be accepted this cycle |

## Verification
Ready responds to a replay request within the same cycle, with no register on the way. The bench samples ready one nanosecond after it drives the inputs at a falling edge. The link word, whether it carries a new flit or a replayed one, is due one rising edge after acceptance, and the bench compares it at the following falling edge. A behavioural model advances by exactly one step per clock edge, so every comparison is made against the value due in that cycle. Mode switches are interleaved with replay requests, so the replay store's gating and recovery are checked at the link.

// File: rtl/xecc_pkg.sv
`timescale 1ns/1ps
package xecc_pkg;

    localparam int MAX_DATA_W = 64;

    typedef enum logic [1:0] {
        XM_SHD_SEC    = 2'b00,
        XM_SHD_SECDED = 2'b01,
        XM_DUP_SECDED = 2'b11
    } xmode_e;

    typedef enum logic [1:0] {
        BUF_EMPTY = 2'b00,
        BUF_HELD  = 2'b01,
        BUF_OFF   = 2'b10
    } buf_state_e;

    function automatic xmode_e decode_mode(input logic [1:0] m);
        xmode_e r;
        unique case (m)
            2'b00:   r = XM_SHD_SEC;
            2'b01:   r = XM_SHD_SECDED;
            default: r = XM_DUP_SECDED;
        endcase
        return r;
    endfunction

    // Column of data bit idx: odd weights from 3 upward, ascending value within a weight.
    function automatic logic [31:0] hsiao_col(input int idx, input int chk_w);
        int n;
        int ones;
        logic [31:0] r;
        n = 0;
        r = '0;
        for (int w = 3; w <= chk_w; w += 2) begin
            for (int v = 0; v < (1 << chk_w); v++) begin
                ones = 0;
                for (int b = 0; b < chk_w; b++) ones += (v >> b) & 1;
                if (ones == w) begin
                    if (n == idx) r = 32'(v);
                    n++;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [MAX_DATA_W-1:0] check_mask(input int j, input int data_w,
                                                         input int chk_w);
        logic [MAX_DATA_W-1:0] m;
        logic [31:0] c;
        m = '0;
        for (int i = 0; i < data_w; i++) begin
            c = hsiao_col(i, chk_w);
            if (c[j]) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/xecc_hsiao_enc.sv
`timescale 1ns/1ps
module xecc_hsiao_enc #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 7
) (
    input  logic [DATA_W-1:0]       data_i,
    input  logic                    drop_top_i,
    output logic [DATA_W+CHK_W-1:0] cw_o
);
    localparam int CW_W = DATA_W + CHK_W;

    assign cw_o[DATA_W-1:0] = data_i;

    for (genvar j = 0; j < CHK_W; j++) begin : g_chk
        localparam logic [xecc_pkg::MAX_DATA_W-1:0] MASK_FULL =
            xecc_pkg::check_mask(j, DATA_W, CHK_W);
        logic parity;
        assign parity = ^(data_i & MASK_FULL[DATA_W-1:0]);
        if (j == CHK_W - 1) begin : g_top
            assign cw_o[CW_W-1] = parity & ~drop_top_i;
        end else begin : g_keep
            assign cw_o[DATA_W+j] = parity;
        end
    end
endmodule

// File: rtl/xecc_wire_map.sv
`timescale 1ns/1ps
module xecc_wire_map #(
    parameter int CW_W = 39
) (
    input  logic [CW_W-1:0]   cw_i,
    input  logic              dup_i,
    output logic [2*CW_W-1:0] wires_o
);
    for (genvar i = 0; i < CW_W; i++) begin : g_pair
        assign wires_o[2*i]   = cw_i[i];
        assign wires_o[2*i+1] = dup_i & cw_i[i];
    end
endmodule

// File: rtl/xecc_replay_buf.sv
`timescale 1ns/1ps
module xecc_replay_buf #(
    parameter int CW_W = 39
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            secded_i,
    input  logic            capture_i,
    input  logic [CW_W-1:0] cw_i,
    input  logic            dup_i,
    input  logic            req_i,
    output logic            grant_o,
    output logic [CW_W-1:0] cw_o,
    output logic            dup_o
);
    import xecc_pkg::*;

    buf_state_e state_q, state_d;
    logic       store_en;
    logic [CW_W-1:0] store_cw_q;
    logic       store_dup_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUF_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!secded_i)      state_d = BUF_OFF;
        else if (capture_i) state_d = BUF_HELD;
        else if (state_q == BUF_OFF) state_d = BUF_EMPTY;
    end

    always_comb begin
        grant_o  = 1'b0;
        store_en = 1'b0;
        unique case (state_q)
            BUF_HELD: begin
                grant_o  = req_i & secded_i;
                store_en = capture_i & secded_i;
            end
            BUF_EMPTY, BUF_OFF: begin
                store_en = capture_i & secded_i;
            end
            default: begin
                grant_o  = 1'b0;
                store_en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_cw_q  <= '0;
            store_dup_q <= 1'b0;
        end else if (store_en) begin
            store_cw_q  <= cw_i;
            store_dup_q <= dup_i;
        end
    end

    assign cw_o  = store_cw_q;
    assign dup_o = store_dup_q;

    assert_gated_in_sec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !secded_i |=> $stable(store_cw_q) && $stable(store_dup_q));

    assert_off_after_sec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !secded_i |=> (state_q == BUF_OFF));

    assert_no_grant_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !secded_i |-> !grant_o);
endmodule

// File: rtl/xtalk_ecc_encoder.sv
`timescale 1ns/1ps
module xtalk_ecc_encoder #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [DATA_W-1:0]               flit_i,
    input  logic                            flit_valid_i,
    input  logic [1:0]                      mode_i,
    input  logic                            replay_req_i,
    output logic [2*(DATA_W+CHK_W)-1:0]     link_o,
    output logic                            ready_o
);
    import xecc_pkg::*;

    localparam int CW_W   = DATA_W + CHK_W;
    localparam int LINK_W = 2 * CW_W;

    xmode_e          cur_mode;
    logic            is_dup, is_secded;
    logic            grant, send;
    logic [CW_W-1:0] enc_cw, buf_cw;
    logic            buf_dup;
    logic [CW_W-1:0] stage_cw_q;
    logic            stage_dup_q;

    assign cur_mode  = decode_mode(mode_i);
    assign is_dup    = (cur_mode == XM_DUP_SECDED);
    assign is_secded = (cur_mode != XM_SHD_SEC);
    assign ready_o   = ~grant;
    assign send      = flit_valid_i & ready_o;

    xecc_hsiao_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
        .data_i     (flit_i),
        .drop_top_i (~is_secded),
        .cw_o       (enc_cw)
    );

    xecc_replay_buf #(.CW_W(CW_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .secded_i  (is_secded),
        .capture_i (send),
        .cw_i      (enc_cw),
        .dup_i     (is_dup),
        .req_i     (replay_req_i),
        .grant_o   (grant),
        .cw_o      (buf_cw),
        .dup_o     (buf_dup)
    );

    // Pipeline stage ahead of the crosstalk mapping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_cw_q  <= '0;
            stage_dup_q <= 1'b0;
        end else if (grant) begin
            stage_cw_q  <= buf_cw;
            stage_dup_q <= buf_dup;
        end else if (send) begin
            stage_cw_q  <= enc_cw;
            stage_dup_q <= is_dup;
        end
    end

    xecc_wire_map #(.CW_W(CW_W)) u_map (
        .cw_i    (stage_cw_q),
        .dup_i   (stage_dup_q),
        .wires_o (link_o)
    );

    function automatic logic pairs_equal(input logic [LINK_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < CW_W; i++) if (w[2*i] != w[2*i+1]) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic odd_clear(input logic [LINK_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < CW_W; i++) if (w[2*i+1]) ok = 1'b0;
        return ok;
    endfunction

    assert_ready_low_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> replay_req_i);

    assert_sec_ignores_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |-> ready_o);

    assert_replay_repeats_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> $stable(link_o));

    assert_dup_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid_i && ready_o && mode_i[1]) |=> pairs_equal(link_o));

    assert_shield_odd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid_i && ready_o && !mode_i[1]) |=> odd_clear(link_o));

    assert_sec_top_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid_i && ready_o && mode_i == 2'b00) |=> !link_o[LINK_W-2]);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flit_valid_i && !replay_req_i) |=> $stable(link_o));
endmodule

// File: tb/xtalk_ecc_encoder_test.sv
`timescale 1ns/1ps
module xtalk_ecc_encoder_test;
    localparam int DW = 32;
    localparam int CW = 39;
    localparam int LW = 78;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] flit_i = '0;
    logic          flit_valid_i = 1'b0;
    logic [1:0]    mode_i = 2'b11;
    logic          replay_req_i = 1'b0;
    logic [LW-1:0] link_o;
    logic          ready_o;

    always #2 clk = ~clk;

    xtalk_ecc_encoder uut (
        .clk(clk), .rst_n(rst_n), .flit_i(flit_i), .flit_valid_i(flit_valid_i),
        .mode_i(mode_i), .replay_req_i(replay_req_i), .link_o(link_o), .ready_o(ready_o)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int            col[DW];
    logic [LW-1:0] m_link;
    int            m_state;   // 0 empty, 1 held, 2 gated
    logic [CW-1:0] m_cw;
    bit            m_dup;

    function automatic logic [CW-1:0] ref_cw(input logic [DW-1:0] d, input bit sec);
        logic [CW-1:0] c;
        bit p;
        c = '0;
        c[DW-1:0] = d;
        for (int j = 0; j < 7; j++) begin
            p = 0;
            for (int i = 0; i < DW; i++) if ((col[i] >> j) & 1) p ^= d[i];
            c[DW+j] = p;
        end
        if (sec) c[CW-1] = 1'b0;
        return c;
    endfunction

    function automatic logic [LW-1:0] ref_map(input logic [CW-1:0] c, input bit dup);
        logic [LW-1:0] w;
        w = '0;
        for (int i = 0; i < CW; i++) begin
            w[2*i] = c[i];
            if (dup) w[2*i+1] = c[i];
        end
        return w;
    endfunction

    task automatic check_link(input string tag);
        checks++;
        if (link_o !== m_link) begin
            failures++;
            $display("FAIL %s link got %h expected %h", tag, link_o, m_link);
        end
    endtask

    task automatic check_ready(input string tag, input bit exp);
        checks++;
        if (ready_o !== exp) begin
            failures++;
            $display("FAIL %s ready got %b expected %b", tag, ready_o, exp);
        end
    endtask

    task automatic step(input bit v, input logic [DW-1:0] d, input logic [1:0] m,
                        input bit rq, input string tag);
        bit secded, dup, grant;
        logic [CW-1:0] c;
        flit_valid_i = v;
        flit_i       = d;
        mode_i       = m;
        replay_req_i = rq;
        #1;
        secded = (m != 2'b00);
        dup    = m[1];
        grant  = rq && secded && (m_state == 1);
        check_ready(tag, !grant);
        @(posedge clk);
        if (grant) begin
            m_link = ref_map(m_cw, m_dup);
        end else if (v) begin
            c = ref_cw(d, !secded);
            m_link = ref_map(c, dup);
            if (secded) begin
                m_cw  = c;
                m_dup = dup;
            end
        end
        if (!secded)           m_state = 2;
        else if (v && !grant)  m_state = 1;
        else if (m_state == 2) m_state = 0;
        @(negedge clk);
        check_link(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        n = 0;
        for (int w = 3; w <= 7; w += 2)
            for (int v = 0; v < 128; v++)
                if ($countones(v) == w && n < DW) begin
                    col[n] = v;
                    n++;
                end
        m_link  = '0;
        m_state = 0;
        m_cw    = '0;
        m_dup   = 0;

        repeat (3) @(negedge clk);
        check_link("R1");
        check_ready("R1", 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: replay before any send is ignored
        step(0, 32'h0, 2'b11, 1, "R1");
        // R2: encoding under several patterns (shielded shows the codeword directly)
        step(1, 32'h0000_0000, 2'b11, 0, "R2");
        step(1, 32'hFFFF_FFFF, 2'b01, 0, "R2");
        for (int k = 0; k < DW; k++) step(1, 32'h1 << k, 2'b01, 0, "R2");
        step(1, 32'h8421_0F0F, 2'b01, 0, "R2");
        // R4, R5, R6, R3 mappings
        step(1, 32'hA5A5_5A5A, 2'b11, 0, "R4");
        step(1, 32'h1234_5678, 2'b01, 0, "R5");
        step(1, 32'hDEAD_BEEF, 2'b00, 0, "R6");
        step(1, 32'hFFFF_FFFF, 2'b00, 0, "R6");
        step(1, 32'hDEAD_BEEF, 2'b10, 0, "R3");
        step(1, 32'h7777_1111, 2'b10, 0, "R3");
        // R7: idle holds
        step(0, 32'hFFFF_0000, 2'b11, 0, "R7");
        step(0, 32'h0000_FFFF, 2'b01, 0, "R7");
        // R8/R10: replay in duplicated mode, offered flit refused
        step(1, 32'h0BAD_F00D, 2'b11, 0, "R8");
        step(1, 32'hCAFE_0001, 2'b11, 1, "R8");
        step(0, 32'h0, 2'b11, 1, "R10");
        step(0, 32'h0, 2'b11, 0, "R10");
        // R8: stored shielded word replayed with its own mapping
        step(1, 32'h1357_9BDF, 2'b01, 0, "R8");
        step(0, 32'h0, 2'b11, 1, "R8");
        // R9: SEC ignores requests, store gated
        step(1, 32'h2468_ACE0, 2'b00, 1, "R9");
        step(0, 32'h0, 2'b00, 1, "R9");
        step(0, 32'h0, 2'b01, 1, "R9");
        step(0, 32'h0, 2'b01, 1, "R9");
        step(1, 32'h1111_2222, 2'b01, 0, "R9");
        step(0, 32'h0, 2'b01, 1, "R10");
        step(1, 32'h3333_4444, 2'b01, 1, "R10");
        // R7: mixed random traffic
        for (int t = 0; t < 400; t++)
            step(1'($urandom % 2), $urandom, 2'($urandom % 4), ($urandom % 4) == 0, "R7");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule